// File: doc/BRIEF.md
# Chained Descriptor Reloader

This block refills one DMA channel's working registers from a descriptor held in memory once the channel's element count has run out. The channel logic gives it a start pulse and the channel's present chain pointer. The block reads the four-word descriptor that pointer names over a simple request/response memory port, one read at a time. It then hands the new source address, destination address, control word and chain pointer back to the channel register file in a single load cycle.

A zero chain pointer marks the end of a chain. In that case nothing is read and the block tells the channel to drop its enable bit. If any read returns an error, the reload is abandoned. The block then raises the channel's raw error flag and drops its enable. Arbitration between channels and the element moves themselves are handled elsewhere.

The descriptor is four 32-bit words with the lowest-addressed byte in bits 7:0 of the data bus. From the chain pointer: +0 is the source address, +4 the destination address, +8 the next chain pointer, and +12 the control word. Bit 31 of the control word asks for a terminal-count interrupt.

Top module: `chain_loader`

## Requirements
- R1: While reset is held and right after it, busy_o, mem_req_valid_o, load_o, chan_off_o, err_set_o and tc_irq_o are all low.
- R2: A start pulse with a nonzero pointer P, taken while idle, produces four reads at P+0, P+4, P+8 and P+12, in that order, all derived from P. Each read holds mem_req_valid_o and mem_req_addr_o steady until mem_req_ready_i is seen high at a clock edge.
- R3: Only one read is outstanding at a time. After a request is accepted, mem_req_valid_o stays low until the response for that read has arrived.
- R4: The clock edge that takes the fourth good response makes load_o high for exactly one cycle. During that cycle the outputs carry the loaded descriptor: src_o is the word from P+0, dst_o the word from P+4, link_o the word from P+8 and ctl_o the word from P+12.
- R5: A start pulse with a zero pointer issues no read. It makes chan_off_o high for one cycle, the cycle after the start, with load_o and err_set_o low.
- R6: tc_irq_o is high in the load cycle exactly when bit 31 of the newly loaded control word is 1, and low in every other cycle.
- R7: A response with mem_rsp_err_i high ends the reload. In the following cycle err_set_o and chan_off_o are both high for one cycle. No further read is issued and load_o never rises for that reload.
- R8: busy_o is high from the cycle after an accepted start through the result cycle (load or channel-off), and low in the cycle after. A start pulse that arrives while busy_o is high is ignored and changes no read address.
- R9: After a load or channel-off result, a start pulse in the very next idle cycle is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a reload, one-cycle pulse |
| link_ptr_i | input | ADDR_W | Channel's current chain pointer, sampled with start_i |
| busy_o | output | 1 | Reload in progress |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_addr_o | output | ADDR_W | Read byte address |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Read data returned |
| mem_rsp_data_i | input | DATA_W | Read data word, lowest byte in bits 7:0 |
| mem_rsp_err_i | input | 1 | Read failed, qualified by mem_rsp_valid_i |
| load_o | output | 1 | Write the four fields into the channel, one-cycle pulse |
| src_o | output | DATA_W | New source address |
| dst_o | output | DATA_W | New destination address |
| ctl_o | output | DATA_W | New control word |
| link_o | output | DATA_W | New chain pointer |
| tc_irq_o | output | 1 | Set the channel's terminal-count flag |
| chan_off_o | output | 1 | Clear the channel's enable bit |
| err_set_o | output | 1 | Set the channel's raw error flag |

## Verification
Two events can meet in one cycle: the result cycle of one reload, and the channel's next start pulse. The bench raises start_i during the load cycle and checks that busy_o stays low afterwards and that no read appears, so the early pulse is ignored. It then starts again in the first idle cycle and checks that the new chain is read from the new pointer. An error on the fourth word also coincides with the point where a load would happen. That case is judged by err_set_o and chan_off_o rising while load_o stays low.

// File: rtl/chain_pkg.sv
package chain_pkg;

    localparam int unsigned NUM_WORDS  = 4;
    localparam int unsigned IDX_W      = $clog2(NUM_WORDS);
    localparam int unsigned BYTE_SHIFT = 2;

    // word slots inside a descriptor, by address order
    localparam int unsigned SLOT_SRC  = 0;
    localparam int unsigned SLOT_DST  = 1;
    localparam int unsigned SLOT_LINK = 2;
    localparam int unsigned SLOT_CTL  = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_AWAIT  = 2'd2,
        ST_RESULT = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        OUT_LOAD = 2'd0,
        OUT_END  = 2'd1,
        OUT_FAIL = 2'd2
    } outcome_e;

endpackage

// File: rtl/chain_capture.sv
module chain_capture
    import chain_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en_i,
    input  logic [IDX_W-1:0]                   wr_idx_i,
    input  logic [DATA_W-1:0]                  wr_data_i,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]   words_o
);

    logic [NUM_WORDS-1:0][DATA_W-1:0] words_d, words_q;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
        always_comb begin
            words_d[g] = words_q[g];
            if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                words_d[g] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_q <= '0;
        end else begin
            words_q <= words_d;
        end
    end

    assign words_o = words_q;

endmodule

// File: rtl/chain_seq.sv
module chain_seq
    import chain_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] link_ptr_i,
    input  logic              mem_req_ready_i,
    input  logic              mem_rsp_valid_i,
    input  logic              mem_rsp_err_i,
    output logic              busy_o,
    output logic              mem_req_valid_o,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    output logic              cap_en_o,
    output logic [IDX_W-1:0]  cap_idx_o,
    output logic              load_o,
    output logic              chan_off_o,
    output logic              err_set_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        seq_state_e        state;
        outcome_e          outcome;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (link_ptr_i == '0) begin
                        s_d.state   = ST_RESULT;
                        s_d.outcome = OUT_END;
                    end else begin
                        s_d.state = ST_ISSUE;
                        s_d.base  = link_ptr_i;
                        s_d.idx   = '0;
                    end
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready_i) begin
                    s_d.state = ST_AWAIT;
                end
            end
            ST_AWAIT: begin
                if (mem_rsp_valid_i) begin
                    if (mem_rsp_err_i) begin
                        s_d.state   = ST_RESULT;
                        s_d.outcome = OUT_FAIL;
                    end else if (s_q.idx == LAST_IDX) begin
                        s_d.state   = ST_RESULT;
                        s_d.outcome = OUT_LOAD;
                    end else begin
                        s_d.state = ST_ISSUE;
                        s_d.idx   = s_q.idx + 1'b1;
                    end
                end
            end
            ST_RESULT: begin
                s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, outcome: OUT_LOAD, idx: '0, base: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o          = (s_q.state != ST_IDLE);
    assign mem_req_valid_o = (s_q.state == ST_ISSUE);
    assign mem_req_addr_o  = s_q.base + ADDR_W'({s_q.idx, BYTE_SHIFT'(0)});
    assign cap_en_o        = (s_q.state == ST_AWAIT) && mem_rsp_valid_i && !mem_rsp_err_i;
    assign cap_idx_o       = s_q.idx;
    assign load_o          = (s_q.state == ST_RESULT) && (s_q.outcome == OUT_LOAD);
    assign chan_off_o      = (s_q.state == ST_RESULT) && (s_q.outcome != OUT_LOAD);
    assign err_set_o       = (s_q.state == ST_RESULT) && (s_q.outcome == OUT_FAIL);

endmodule

// File: rtl/chain_loader.sv
module chain_loader
    import chain_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] link_ptr_i,
    output logic              busy_o,
    output logic              mem_req_valid_o,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_req_ready_i,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i,
    input  logic              mem_rsp_err_i,
    output logic              load_o,
    output logic [DATA_W-1:0] src_o,
    output logic [DATA_W-1:0] dst_o,
    output logic [DATA_W-1:0] ctl_o,
    output logic [DATA_W-1:0] link_o,
    output logic              tc_irq_o,
    output logic              chan_off_o,
    output logic              err_set_o
);

    localparam int unsigned TC_BIT = DATA_W - 1;

    logic                             cap_en;
    logic [IDX_W-1:0]                 cap_idx;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;

    chain_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .link_ptr_i      (link_ptr_i),
        .mem_req_ready_i (mem_req_ready_i),
        .mem_rsp_valid_i (mem_rsp_valid_i),
        .mem_rsp_err_i   (mem_rsp_err_i),
        .busy_o          (busy_o),
        .mem_req_valid_o (mem_req_valid_o),
        .mem_req_addr_o  (mem_req_addr_o),
        .cap_en_o        (cap_en),
        .cap_idx_o       (cap_idx),
        .load_o          (load_o),
        .chan_off_o      (chan_off_o),
        .err_set_o       (err_set_o)
    );

    chain_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cap_en),
        .wr_idx_i  (cap_idx),
        .wr_data_i (mem_rsp_data_i),
        .words_o   (words)
    );

    assign src_o    = words[SLOT_SRC];
    assign dst_o    = words[SLOT_DST];
    assign link_o   = words[SLOT_LINK];
    assign ctl_o    = words[SLOT_CTL];
    assign tc_irq_o = load_o && words[SLOT_CTL][TC_BIT];

endmodule

// File: rtl/chain_loader_chk.sv
module chain_loader_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] link_ptr_i,
    input logic              busy_o,
    input logic              mem_req_valid_o,
    input logic [ADDR_W-1:0] mem_req_addr_o,
    input logic              mem_req_ready_i,
    input logic              load_o,
    input logic              tc_irq_o,
    input logic              chan_off_o,
    input logic              err_set_o
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R2

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o); // R3

    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_o, chan_off_o})); // R4

    AST_ZERO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (link_ptr_i == '0) |=> chan_off_o && !err_set_o && !mem_req_valid_o); // R5

    AST_TC_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tc_irq_o |-> load_o); // R6

    AST_ERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        err_set_o |-> chan_off_o && !load_o); // R7

    AST_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        load_o || chan_off_o |=> !busy_o); // R8

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o); // R9

endmodule

bind chain_loader chain_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .link_ptr_i      (link_ptr_i),
    .busy_o          (busy_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_ready_i (mem_req_ready_i),
    .load_o          (load_o),
    .tc_irq_o        (tc_irq_o),
    .chan_off_o      (chan_off_o),
    .err_set_o       (err_set_o)
);

// File: tb/sim_chain_loader.sv
`timescale 1ns/1ps
module sim_chain_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] link_ptr_i = '0;
    logic        busy_o, mem_req_valid_o, mem_req_ready_i = 1'b0;
    logic [31:0] mem_req_addr_o;
    logic        mem_rsp_valid_i = 1'b0, mem_rsp_err_i = 1'b0;
    logic [31:0] mem_rsp_data_i = '0;
    logic        load_o, tc_irq_o, chan_off_o, err_set_o;
    logic [31:0] src_o, dst_o, ctl_o, link_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    chain_loader u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .link_ptr_i(link_ptr_i),
        .busy_o(busy_o), .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
        .mem_req_ready_i(mem_req_ready_i), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_data_i(mem_rsp_data_i), .mem_rsp_err_i(mem_rsp_err_i),
        .load_o(load_o), .src_o(src_o), .dst_o(dst_o), .ctl_o(ctl_o), .link_o(link_o),
        .tc_irq_o(tc_irq_o), .chan_off_o(chan_off_o), .err_set_o(err_set_o)
    );

    typedef struct packed {
        logic [31:0] ptr;
        logic [3:0]  rdly;   // cycles before ready
        logic [3:0]  sdly;   // cycles between accept and response
        logic [2:0]  err_at; // word that fails, 4 = none
        logic        poke;   // start pulse while waiting
        logic        tail;   // start pulse in the load cycle
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 4'd0, 4'd0, 3'd4, 1'b0, 1'b0},
        '{32'h0000_2040, 4'd2, 4'd1, 3'd4, 1'b0, 1'b1},
        '{32'h0003_0100, 4'd1, 4'd3, 3'd4, 1'b1, 1'b0},
        '{32'h0000_4440, 4'd0, 4'd2, 3'd2, 1'b0, 1'b0},
        '{32'h0000_5000, 4'd3, 4'd0, 3'd0, 1'b0, 1'b0},
        '{32'h0000_6FF0, 4'd0, 4'd0, 3'd3, 1'b0, 1'b0},
        '{32'h0000_7FC0, 4'd1, 4'd1, 3'd4, 1'b0, 1'b0}
    };

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[6], 7'h15, a[23:0] ^ 24'hC3A5F0};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] a;
        start_i = 1'b1; link_ptr_i = v.ptr;
        @(negedge clk);
        start_i = 1'b0; link_ptr_i = '0;
        chk(busy_o == 1'b1, "R8", "busy after start", {31'd0, busy_o}, 32'd1);
        for (int k = 0; k < 4; k++) begin
            a = v.ptr + 32'(4 * k);
            chk(mem_req_valid_o == 1'b1, "R2", "request raised", {31'd0, mem_req_valid_o}, 32'd1);
            for (int d = 0; d < int'(v.rdly); d++) begin
                @(negedge clk);
                chk(mem_req_valid_o && mem_req_addr_o == a, "R2", "request held", mem_req_addr_o, a);
            end
            chk(mem_req_addr_o == a, "R2", "read address", mem_req_addr_o, a);
            mem_req_ready_i = 1'b1;
            @(negedge clk);
            mem_req_ready_i = 1'b0;
            chk(mem_req_valid_o == 1'b0, "R3", "no second request", {31'd0, mem_req_valid_o}, 32'd0);
            if (v.poke && k == 0) begin
                start_i = 1'b1; link_ptr_i = 32'hDEAD_0000;
                @(negedge clk);
                start_i = 1'b0; link_ptr_i = '0;
                chk(mem_req_valid_o == 1'b0 && busy_o, "R8", "start ignored while busy",
                    {31'd0, mem_req_valid_o}, 32'd0);
            end
            for (int d = 0; d < int'(v.sdly); d++) begin
                @(negedge clk);
                chk(mem_req_valid_o == 1'b0, "R3", "quiet while waiting", {31'd0, mem_req_valid_o}, 32'd0);
            end
            mem_rsp_valid_i = 1'b1;
            mem_rsp_data_i  = mem_word(a);
            mem_rsp_err_i   = (int'(v.err_at) == k);
            @(negedge clk);
            mem_rsp_valid_i = 1'b0;
            mem_rsp_err_i   = 1'b0;
            if (int'(v.err_at) == k) begin
                chk(err_set_o && chan_off_o && !load_o, "R7", "error result",
                    {29'd0, err_set_o, chan_off_o, load_o}, 32'h6);
                @(negedge clk);
                chk(!busy_o && !mem_req_valid_o && !load_o, "R7", "aborted, idle",
                    {30'd0, busy_o, mem_req_valid_o}, 32'd0);
                return;
            end
        end
        chk(load_o == 1'b1, "R4", "load pulse", {31'd0, load_o}, 32'd1);
        chk(src_o == mem_word(v.ptr), "R4", "source word", src_o, mem_word(v.ptr));
        chk(dst_o == mem_word(v.ptr + 4), "R4", "dest word", dst_o, mem_word(v.ptr + 4));
        chk(link_o == mem_word(v.ptr + 8), "R4", "next pointer", link_o, mem_word(v.ptr + 8));
        chk(ctl_o == mem_word(v.ptr + 12), "R4", "control word", ctl_o, mem_word(v.ptr + 12));
        chk(tc_irq_o == mem_word(v.ptr + 12)[31], "R6", "tc request", {31'd0, tc_irq_o},
            {31'd0, mem_word(v.ptr + 12)[31]});
        chk(chan_off_o == 1'b0 && busy_o, "R8", "busy in load cycle", {31'd0, chan_off_o}, 32'd0);
        if (v.tail) begin
            start_i = 1'b1; link_ptr_i = 32'h0000_9000;
        end
        @(negedge clk);
        start_i = 1'b0; link_ptr_i = '0;
        chk(!busy_o && !load_o && !tc_irq_o, "R8", "idle after load",
            {29'd0, busy_o, load_o, tc_irq_o}, 32'd0);
        if (v.tail) begin
            @(negedge clk);
            chk(!busy_o && !mem_req_valid_o, "R8", "start in load cycle ignored",
                {30'd0, busy_o, mem_req_valid_o}, 32'd0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !mem_req_valid_o && !load_o && !chan_off_o && !err_set_o && !tc_irq_o,
            "R1", "outputs in reset", {31'd0, busy_o | mem_req_valid_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !mem_req_valid_o && !load_o && !chan_off_o, "R1", "outputs after reset",
            {31'd0, busy_o | mem_req_valid_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R5: zero pointer ends the chain without reads
        start_i = 1'b1; link_ptr_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        chk(chan_off_o && !load_o && !err_set_o && !mem_req_valid_o && busy_o, "R5",
            "zero pointer result", {28'd0, chan_off_o, load_o, err_set_o, mem_req_valid_o}, 32'h8);
        @(negedge clk);
        chk(!busy_o && !chan_off_o && !mem_req_valid_o, "R5", "zero pointer one cycle",
            {30'd0, busy_o, chan_off_o}, 32'd0);

        // R9: start right after a channel-off result is taken at once
        run_vec('{32'h0000_0A00, 4'd0, 4'd0, 3'd4, 1'b0, 1'b0});

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule